// File: doc/BRIEF.md
# Repeat-Mode DMA Channel Sequencer

This block is one DMA channel that runs without pause in repeat mode. Software loads a 24-bit memory address, a 16-bit I/O address, a transfer count and a control word. Each single-cycle pulse on `dreq` then moves one byte or one word between the memory address and the I/O address. The move is a read bus cycle from the source followed by a write bus cycle to the destination, and `dack` pulses once the write is accepted. After each move the memory address steps and the working count drops by one. When the working count reaches zero, the channel restores both the memory address and the count to the values software loaded, and it keeps accepting requests. The sequence repeats with no further programming.

The I/O side of every transfer uses the 16-bit I/O address with its upper byte forced to all ones, and that address never changes. A direction bit picks which side is the source. Requests that arrive while a transfer is running are counted and then served one at a time.

The sequencer has four states. S_IDLE waits for a pending request while the channel is active, then goes to S_RD. S_RD holds a read cycle until `bus_ready` and latches the data, then goes to S_WR. S_WR holds the write cycle until `bus_ready`, then goes to S_DONE. S_DONE raises `dack`, updates the address and the count, and returns to S_IDLE.

Top module: `rpt_dma_chan`

## Requirements
- R1: The channel is active only when control bit 0 (enable) is 1, control bit 1 (repeat enable) is 1 and control bit 2 (end interrupt enable) is 0. While it is inactive, `dreq` pulses are ignored, pending requests are dropped and no bus cycle starts from S_IDLE.
- R2: Each accepted request makes exactly one read cycle (`bus_we`=0) and then one write cycle (`bus_we`=1). The write carries the data returned by the read. `dack` is high for exactly the one clock after the write is accepted, and no bus cycle is requested during that clock.
- R3: When control bit 3 (direction) is 0, the memory address is the source and the I/O address is the destination. When it is 1, the two roles swap.
- R4: The I/O side address is {0xFF, I/O register} and stays fixed across transfers.
- R5: Control bit 4 selects word transfers (step 2, `bus_word`=1) over byte transfers (step 1). Control bit 5 makes the step subtract instead of add. The address wraps modulo 2^24.
- R6: The working count decrements once per transfer. On the transfer that brings it to zero, it reloads from the programmed count and the memory address is restored to its start value instead of stepping.
- R7: A write with `cfg_sel`=0 sets both the memory address and its saved start value. `cfg_sel`=1 sets the I/O register from `cfg_wdata[15:0]`. `cfg_sel`=2 sets both the programmed and the working count from `cfg_wdata[7:0]`. `cfg_sel`=3 sets the control bits from `cfg_wdata[5:0]`.
- R8: Requests that arrive during a transfer are held pending, up to 2^PEND_W-1 of them (further ones are lost), and are then served one per transfer.
- R9: Disabling the channel during a transfer lets that transfer finish and update its registers normally. No further transfer starts, and a later transfer continues from the updated address and count.
- R10: After reset the channel is idle with `bus_req`=0 and `dack`=0.
- R11: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_we` and `bus_addr` hold their values into the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 memory address, 1 I/O address, 2 count, 3 control |
| cfg_wdata | input | 24 | Register write data |
| dreq | input | 1 | Transfer request, one request per high clock |
| dack | output | 1 | One-clock acknowledge after the write cycle |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = word access, 0 = byte access |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Bus cycle accepted this clock |

## Verification
The bench builds the channel with 24-bit memory addresses, a 16-bit I/O register, an 8-bit count, and PEND_W set to 2 so the pending queue is only three deep. With that depth, a burst of six requests during a slow transfer fills and overflows the queue, and the bench can predict exactly how many transfers run. The bench uses small programmed counts (2 and 3), so the zero-count reload and the address restore happen several times in one run. A start address of 0xFFFFFF brings the 24-bit wrap into reach. Bus latencies of 0, 2, 4 and 6 clocks exercise the hold behaviour.

// File: rtl/rpt_dma_pkg.sv
package rpt_dma_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2,
        S_DONE = 2'd3
    } dma_state_e;

    typedef struct packed {
        logic dec;
        logic word;
        logic dir;
        logic tie;
        logic rpt;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] SEL_MAR  = 2'd0;
    localparam logic [1:0] SEL_IOAR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/rpt_dma_regs.sv
module rpt_dma_regs
    import rpt_dma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              upd,
    output logic [ADDR_W-1:0] mar,
    output logic [ADDR_W-1:0] io_addr,
    output ctrl_t             ctrl
);
    localparam int FILL_W = ADDR_W - IO_W;

    logic [ADDR_W-1:0] shadow;
    logic [IO_W-1:0]   ioar;
    logic [CNT_W-1:0]  cnt_hi;
    logic [CNT_W-1:0]  cnt_lo;
    logic [CNT_W-1:0]  cnt_dec;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] mar_step;

    assign io_addr  = {{FILL_W{1'b1}}, ioar};
    assign cnt_dec  = cnt_lo - CNT_W'(1);
    assign step     = ctrl.word ? ADDR_W'(2) : ADDR_W'(1);
    assign mar_step = ctrl.dec ? (mar - step) : (mar + step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar    <= '0;
            shadow <= '0;
            ioar   <= '0;
            cnt_hi <= '0;
            cnt_lo <= '0;
            ctrl   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_MAR: begin
                    mar    <= cfg_wdata;
                    shadow <= cfg_wdata;
                end
                SEL_IOAR: ioar <= cfg_wdata[IO_W-1:0];
                SEL_CNT: begin
                    cnt_hi <= cfg_wdata[CNT_W-1:0];
                    cnt_lo <= cfg_wdata[CNT_W-1:0];
                end
                SEL_CTRL: ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            endcase
        end else if (upd) begin
            if (cnt_dec == '0) begin
                cnt_lo <= cnt_hi;
                mar    <= shadow;
            end else begin
                cnt_lo <= cnt_dec;
                mar    <= mar_step;
            end
        end
    end

    // R6: the last transfer of a round restores the count and the address
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !cfg_we && cnt_lo == CNT_W'(1)) |=> (cnt_lo == cnt_hi && mar == shadow));

    // R7: the saved start address changes only on a memory-address write
    p_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == SEL_MAR) |=> $stable(shadow));

endmodule

// File: rtl/rpt_dma_req.sv
module rpt_dma_req #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic active,
    input  logic take,
    output logic pend_nz
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] pend;
    logic              inc;

    assign inc     = dreq && active && (pend != PEND_MAX || take);
    assign pend_nz = (pend != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (!active) begin
            pend <= '0;
        end else if (inc && !take) begin
            pend <= pend + PEND_W'(1);
        end else if (take && !inc) begin
            pend <= pend - PEND_W'(1);
        end
    end

    // R8: a full queue stays full and never wraps to empty
    p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pend == PEND_MAX && !take) |=> (pend == PEND_MAX || !active));

    // R1: the queue is empty one clock after the channel goes inactive
    p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pend_nz);

endmodule

// File: rtl/rpt_dma_fsm.sv
module rpt_dma_fsm
    import rpt_dma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              pend_nz,
    input  logic              dir,
    input  logic              word,
    input  logic [ADDR_W-1:0] mar,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              take,
    output logic              upd,
    output logic              dack,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    dma_state_e        state, state_nx;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;

    assign src_addr = dir ? io_addr : mar;
    assign dst_addr = dir ? mar : io_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == S_RD && bus_ready) begin
            data_q <= bus_rdata;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (active && pend_nz) state_nx = S_RD;
            S_RD:   if (bus_ready)         state_nx = S_WR;
            S_WR:   if (bus_ready)         state_nx = S_DONE;
            S_DONE:                        state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        take      = 1'b0;
        upd       = 1'b0;
        dack      = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_word  = word;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            S_IDLE: take = active && pend_nz;
            S_RD: begin
                bus_req  = 1'b1;
                bus_addr = src_addr;
            end
            S_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = dst_addr;
                bus_wdata = data_q;
            end
            S_DONE: begin
                upd  = 1'b1;
                dack = 1'b1;
            end
        endcase
    end

    // R2: acknowledge follows the accepted write by one clock
    p_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ready) |=> dack);

    // R2: no bus cycle during the acknowledge clock
    p_ack_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> !bus_req);

    // R2: a write is always preceded by an accepted read
    p_rd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> $past(bus_req && !bus_we && bus_ready));

    // R1: an inactive idle channel starts nothing
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !active) |=> !bus_req);

    // R11: a stalled bus cycle holds its request, kind and address
    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

endmodule

// File: rtl/rpt_dma_chan.sv
module rpt_dma_chan
    import rpt_dma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dreq,
    output logic              dack,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    localparam int FILL_W = ADDR_W - IO_W;

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] mar;
    logic [ADDR_W-1:0] io_addr;
    logic              active;
    logic              pend_nz;
    logic              take;
    logic              upd;

    assign active = ctrl.en && ctrl.rpt && !ctrl.tie;

    rpt_dma_regs #(
        .ADDR_W(ADDR_W),
        .IO_W  (IO_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .upd      (upd),
        .mar      (mar),
        .io_addr  (io_addr),
        .ctrl     (ctrl)
    );

    rpt_dma_req #(
        .PEND_W(PEND_W)
    ) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .dreq   (dreq),
        .active (active),
        .take   (take),
        .pend_nz(pend_nz)
    );

    rpt_dma_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .pend_nz  (pend_nz),
        .dir      (ctrl.dir),
        .word     (ctrl.word),
        .mar      (mar),
        .io_addr  (io_addr),
        .bus_ready(bus_ready),
        .bus_rdata(bus_rdata),
        .take     (take),
        .upd      (upd),
        .dack     (dack),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_word (bus_word),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata)
    );

    // R4: the I/O side of each cycle carries the all-ones upper byte
    p_io_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_we != ctrl.dir)) |-> (bus_addr[ADDR_W-1:IO_W] == {FILL_W{1'b1}}));

endmodule

// File: tb/test_rpt_dma_chan.sv
module test_rpt_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic        dreq = 1'b0;
    logic        dack, bus_req, bus_we, bus_word, bus_ready;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int lat = 0;
    int wcnt = 0;
    int xfers = 0;
    bit ack_exp = 1'b0;
    logic [15:0] rd_seen = '0;
    logic [23:0] mq[$];

    // behavioural reference state
    int unsigned m_mar = 0, m_shadow = 0, m_io = 0, m_hi = 0, m_lo = 0;
    bit m_dir = 0, m_word = 0, m_dec = 0;

    always #10 clk = ~clk;

    assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;
    assign bus_ready = bus_req && (wcnt >= lat);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        wcnt   <= (bus_req && !bus_ready) ? wcnt + 1 : 0;
    end

    rpt_dma_chan #(.PEND_W(2)) i_rpt_dma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .bus_req(bus_req),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 100000);
            report();
        end
    end

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            int unsigned io_full, src, dst, step;
            check(dack === ack_exp, "R2 dack timing", dack, ack_exp);
            ack_exp = 1'b0;
            io_full = 32'hFF0000 | m_io;
            src = m_dir ? io_full : m_mar;
            dst = m_dir ? m_mar : io_full;
            if (bus_req && bus_ready) begin
                check(bus_word === m_word, "R5 bus_word", bus_word, m_word);
                if (!bus_we) begin
                    check(bus_addr == src[23:0], "R3 R4 R5 R6 read address", bus_addr, src);
                    rd_seen = bus_rdata;
                end else begin
                    check(bus_addr == dst[23:0], "R3 R4 R5 R6 write address", bus_addr, dst);
                    check(bus_wdata == rd_seen, "R2 write data", bus_wdata, rd_seen);
                    mq.push_back(m_mar[23:0]);
                    xfers++;
                    ack_exp = 1'b1;
                    step = m_word ? 2 : 1;
                    m_lo = (m_lo - 1) & 32'hFF;
                    if (m_lo == 0) begin
                        m_lo = m_hi;
                        m_mar = m_shadow;
                    end else begin
                        m_mar = (m_dec ? m_mar - step : m_mar + step) & 32'hFFFFFF;
                    end
                end
            end
        end
    end

    task automatic cfg(input logic [1:0] sel, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            2'd0: begin m_mar = d; m_shadow = d; end
            2'd1: m_io = d[15:0];
            2'd2: begin m_hi = d[7:0]; m_lo = d[7:0]; end
            default: begin m_dir = d[3]; m_word = d[4]; m_dec = d[5]; end
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reqs(input int n);
        @(negedge clk);
        dreq = 1'b1;
        repeat (n) @(negedge clk);
        dreq = 1'b0;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 12) begin
            @(negedge clk);
            q = bus_req ? 0 : q + 1;
        end
    endtask

    task automatic serve(input int n);
        for (int i = 0; i < n; i++) begin
            reqs(1);
            quiet();
        end
    endtask

    task automatic check_seq(input string what, input logic [23:0] exp[]);
        check(mq.size() == exp.size(), what, mq.size(), exp.size());
        for (int i = 0; i < exp.size() && i < mq.size(); i++)
            check(mq[i] == exp[i], what, mq[i], exp[i]);
        mq.delete();
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(bus_req === 1'b0, "R10 bus_req after reset", bus_req, 0);
        check(dack === 1'b0, "R10 dack after reset", dack, 0);
        rst_n = 1'b1;

        // R6 R7: byte, increment, memory to I/O, count 3
        cfg(2'd0, 24'h001000);
        cfg(2'd1, 24'h002040);
        cfg(2'd2, 24'h000003);
        cfg(2'd3, 24'h000003);
        serve(7);
        check_seq("R6 R7 restore sequence",
                  '{24'h001000, 24'h001001, 24'h001002, 24'h001000,
                    24'h001001, 24'h001002, 24'h001000});

        // R3 R5 R6: word, decrement, I/O to memory, count 2, stalled bus
        lat = 2;
        cfg(2'd0, 24'h000010);
        cfg(2'd1, 24'h001234);
        cfg(2'd2, 24'h000002);
        cfg(2'd3, 24'h00003B);
        serve(5);
        check_seq("R5 R6 word decrement sequence",
                  '{24'h000010, 24'h00000E, 24'h000010, 24'h00000E, 24'h000010});

        // R5: wrap at the top of the address space
        lat = 0;
        cfg(2'd0, 24'hFFFFFF);
        cfg(2'd2, 24'h000002);
        cfg(2'd3, 24'h000003);
        serve(3);
        check_seq("R5 wrap sequence", '{24'hFFFFFF, 24'h000000, 24'hFFFFFF});

        // R1: end interrupt enable or cleared repeat enable blocks the channel
        base = xfers;
        cfg(2'd3, 24'h000007);
        reqs(3);
        quiet();
        check(xfers == base, "R1 ignored with end interrupt enable", xfers - base, 0);
        cfg(2'd3, 24'h000001);
        reqs(2);
        quiet();
        check(xfers == base, "R1 ignored without repeat enable", xfers - base, 0);
        cfg(2'd3, 24'h000003);
        serve(1);
        check(xfers == base + 1, "R1 dropped requests not replayed", xfers - base, 1);
        mq.delete();

        // R8: burst of six during a slow transfer, queue depth three
        lat = 6;
        base = xfers;
        reqs(6);
        quiet();
        check(xfers == base + 4, "R8 pending queue", xfers - base, 4);
        mq.delete();

        // R9: disable mid-transfer, then resume
        lat = 4;
        base = xfers;
        reqs(2);
        while (!bus_req) @(negedge clk);
        cfg(2'd3, 24'h000002);
        quiet();
        check(xfers == base + 1, "R9 stop at boundary", xfers - base, 1);
        cfg(2'd3, 24'h000003);
        serve(1);
        check(xfers == base + 2, "R9 resume after enable", xfers - base, 2);

        report();
    end
endmodule